// File: doc/BRIEF.md
# Delayed write retry controller

This block owns a single delayed write that a bridge has taken from an initiator and must now deliver on the target bus. Once the request is accepted, the block starts one attempt at a time. A bus-engine stub carries out each attempt and reports back a termination code. Every retry result adds one to an attempt counter. The block stops retrying when data moves, when an abort comes back, or when the counter reaches a programmable limit.

For every result, the block produces a one-cycle completion response for the initiator side. It also updates three sticky status bits that software clears by writing one. When delivery fails at the limit, it can pulse a system-error request. Only one delayed write can be outstanding at a time.

Top module: `dw_retry_ctrl`

## Requirements
- R1: `req_ready_o` is high only when no delayed write is active. A `req_valid_i` seen while a delayed write is active is ignored.
- R2: `att_start_o` pulses for one cycle in the cycle after a request is accepted. It pulses again in the cycle after each retry result that does not hit the limit.
- R3: A retry result (term code 1) below the limit returns response code 1 (retry), and the block keeps the request active.
- R4: A normal result (term 0) or a disconnect result (term 2) returns response 2 (disconnect) when `req_multi_i` was set at acceptance. Otherwise it returns response 0 (done). In both cases the block goes idle.
- R5: A target abort result (term 3) returns response 3. It sets status bit 0 (received target abort) and status bit 1 (signaled target abort), and the block goes idle.
- R6: A master abort result (term 4) returns response 4. It sets status bit 2 (received master abort), and the block goes idle.
- R7: When the number of retry results for one request reaches `retry_limit_i` (a value of 0 acts as 1), that retry returns response 5 (dropped) instead of 1. The request is then discarded and the block goes idle.
- R8: On a dropped request, `serr_o` pulses for exactly one cycle, but only if `serr_en_i` is 1 and `nondeliv_dis_i` is 0. Otherwise it stays low.
- R9: The attempt counter restarts from zero for every newly accepted request.
- R10: Status bits are sticky. A 1 in bit i of `sts_clr_i` clears bit i. A set event in the same cycle wins over the clear.
- R11: After reset the block is idle: `req_ready_o`=1, and `att_start_o`, `rsp_valid_o`, `serr_o` and all status bits are 0.
- R12: `rsp_valid_o` pulses for one cycle in the cycle after each result is taken. `rsp_code_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | New delayed write offered |
| req_multi_i | input | 1 | Request asks for more than one data phase |
| req_ready_o | output | 1 | Block idle, request accepted |
| att_start_o | output | 1 | Start one attempt on the target bus |
| res_valid_i | input | 1 | Attempt result present |
| res_term_i | input | 3 | Termination code 0..4 |
| retry_limit_i | input | LIM_W | Retry results allowed per request |
| serr_en_i | input | 1 | System-error enable |
| nondeliv_dis_i | input | 1 | Disable for the non-delivery event |
| sts_clr_i | input | 3 | Write-one-to-clear status strobe |
| rsp_valid_o | output | 1 | Completion response valid |
| rsp_code_o | output | 3 | Completion response code 0..5 |
| sts_o | output | 3 | Sticky status bits |
| serr_o | output | 1 | System-error pulse |

## Verification
The bench drives retry sequences that end exactly at the limit. An off-by-one counter there would return one retry too many or drop the request one attempt early. It repeats a limited request to catch a counter that is not cleared on acceptance, which would drop the second request at once. It toggles the enable and the disable bit, since a wrong gate would raise or hide the error pulse. It also checks that `serr_o` lasts exactly one cycle. It clears one status bit while the others stay set, which catches a clear that wipes all bits. It offers a request while one is busy, which exposes a controller that restarts its counter mid-flight.

// File: rtl/dw_retry_pkg.sv
package dw_retry_pkg;
  typedef enum logic [2:0] {
    TERM_NORMAL = 3'd0,
    TERM_RETRY  = 3'd1,
    TERM_DISC   = 3'd2,
    TERM_TABORT = 3'd3,
    TERM_MABORT = 3'd4
  } term_e;

  typedef enum logic [2:0] {
    RSP_DONE   = 3'd0,
    RSP_RETRY  = 3'd1,
    RSP_DISC   = 3'd2,
    RSP_TABORT = 3'd3,
    RSP_MABORT = 3'd4,
    RSP_DROP   = 3'd5
  } rsp_e;

  localparam int unsigned STS_W      = 3;
  localparam int unsigned STS_RX_TA  = 0;
  localparam int unsigned STS_SIG_TA = 1;
  localparam int unsigned STS_RX_MA  = 2;
endpackage

// File: rtl/dw_attempt_cnt.sv
module dw_attempt_cnt #(
  parameter int unsigned LIM_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             hit_o
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // this retry would be the limit-th one
  assign hit_o   = cnt_nxt >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nxt[LIM_W-1:0];
  end

  p_cnt_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/dw_status_regs.sv
module dw_status_regs #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end

    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
  end
endmodule

// File: rtl/dw_resp_map.sv
module dw_resp_map
  import dw_retry_pkg::*;
(
  input  term_e      term_i,
  input  logic       multi_i,
  input  logic       hit_i,
  output rsp_e       rsp_o,
  output logic [2:0] sts_set_o
);
  always_comb begin
    rsp_o     = RSP_DONE;
    sts_set_o = '0;
    unique case (term_i)
      TERM_NORMAL, TERM_DISC: rsp_o = multi_i ? RSP_DISC : RSP_DONE;
      TERM_RETRY:             rsp_o = hit_i ? RSP_DROP : RSP_RETRY;
      TERM_TABORT: begin
        rsp_o                 = RSP_TABORT;
        sts_set_o[STS_RX_TA]  = 1'b1;
        sts_set_o[STS_SIG_TA] = 1'b1;
      end
      TERM_MABORT: begin
        rsp_o                = RSP_MABORT;
        sts_set_o[STS_RX_MA] = 1'b1;
      end
      default: rsp_o = RSP_DONE;
    endcase
  end
endmodule

// File: rtl/dw_retry_ctrl.sv
module dw_retry_ctrl
  import dw_retry_pkg::*;
#(
  parameter int unsigned LIM_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_multi_i,
  output logic             req_ready_o,
  output logic             att_start_o,
  input  logic             res_valid_i,
  input  logic [2:0]       res_term_i,
  input  logic [LIM_W-1:0] retry_limit_i,
  input  logic             serr_en_i,
  input  logic             nondeliv_dis_i,
  input  logic [2:0]       sts_clr_i,
  output logic             rsp_valid_o,
  output logic [2:0]       rsp_code_o,
  output logic [2:0]       sts_o,
  output logic             serr_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e        st_q, st_d;
  logic       multi_q;
  logic       accept, take, is_retry, hit;
  rsp_e       rsp_d;
  logic [2:0] sts_set, sts_set_q;

  assign req_ready_o = (st_q == ST_IDLE);
  assign att_start_o = (st_q == ST_ISSUE);
  assign accept      = req_valid_i && req_ready_o;
  assign take        = res_valid_i && (st_q == ST_WAIT);
  assign is_retry    = take && (term_e'(res_term_i) == TERM_RETRY);

  dw_attempt_cnt #(.LIM_W(LIM_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (is_retry),
    .limit_i(retry_limit_i),
    .hit_o  (hit)
  );

  dw_resp_map u_map (
    .term_i   (term_e'(res_term_i)),
    .multi_i  (multi_q),
    .hit_i    (hit),
    .rsp_o    (rsp_d),
    .sts_set_o(sts_set)
  );

  assign sts_set_q = take ? sts_set : '0;

  dw_status_regs #(.W(STS_W)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sts_set_q),
    .clr_i (sts_clr_i),
    .q_o   (sts_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (take) st_d = (is_retry && !hit) ? ST_ISSUE : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      multi_q     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= '0;
      serr_o      <= 1'b0;
    end else begin
      st_q        <= st_d;
      if (accept) multi_q <= req_multi_i;
      rsp_valid_o <= take;
      if (take) rsp_code_o <= rsp_d;
      serr_o      <= is_retry && hit && serr_en_i && !nondeliv_dis_i;
    end
  end

  p_busy_ignores_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !res_valid_i) |=> st_q == ST_WAIT);
  p_start_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> att_start_o);
  p_start_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_start_o |=> !att_start_o);
  p_serr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |=> !serr_o);
  p_serr_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> $past(serr_en_i && !nondeliv_dis_i));
  p_tabort_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == RSP_TABORT) |-> (sts_o[STS_RX_TA] && sts_o[STS_SIG_TA]));
  p_drop_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == RSP_DROP) |-> req_ready_o);
  p_rsp_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/dw_retry_ctrl_tb.sv
module dw_retry_ctrl_tb;
  localparam int unsigned LIM_W = 33;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_multi = 1'b0, req_ready;
  logic             att_start, res_valid = 1'b0;
  logic [2:0]       res_term = '0;
  logic [LIM_W-1:0] limit = 33'd3;
  logic             serr_en = 1'b1, dis = 1'b0;
  logic [2:0]       sts_clr = '0;
  logic             rsp_valid, serr;
  logic [2:0]       rsp_code, sts;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dw_retry_ctrl #(.LIM_W(LIM_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_multi_i(req_multi),
    .req_ready_o(req_ready), .att_start_o(att_start), .res_valid_i(res_valid),
    .res_term_i(res_term), .retry_limit_i(limit), .serr_en_i(serr_en),
    .nondeliv_dis_i(dis), .sts_clr_i(sts_clr), .rsp_valid_o(rsp_valid),
    .rsp_code_o(rsp_code), .sts_o(sts), .serr_o(serr)
  );

  // {multi[11], term[10:8], rsp[6:4], sts[2:0]}
  localparam logic [11:0] VEC [6] = '{
    12'b0_000_0_000_0_000,
    12'b1_000_0_010_0_000,
    12'b0_010_0_000_0_000,
    12'b1_010_0_010_0_000,
    12'b0_011_0_011_0_011,
    12'b1_100_0_100_0_100
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // at negedge, idle: accept request; returns at negedge with att_start high
  task automatic start_req(input logic m);
    req_valid = 1'b1; req_multi = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 att_start after accept", att_start, 1);
  endtask

  // at negedge with att_start high: deliver a result; returns at negedge after response
  task automatic give(input logic [2:0] t);
    @(negedge clk);
    res_valid = 1'b1; res_term = t;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clr_all();
    sts_clr = 3'b111;
    @(negedge clk);
    sts_clr = '0;
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 ready", req_ready, 1);
    chk("R11 att_start", att_start, 0);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 serr", serr, 0);
    chk("R11 sts", sts, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R4 R5 R6 R12
    foreach (VEC[i]) begin
      start_req(VEC[i][11]);
      give(VEC[i][10:8]);
      chk("R12 rsp_valid", rsp_valid, 1);
      chk("R4/R5/R6 rsp_code", rsp_code, VEC[i][6:4]);
      chk("R5/R6 status", sts, VEC[i][2:0]);
      chk("R4 back to idle", req_ready, 1);
      @(negedge clk);
      chk("R12 rsp single cycle", rsp_valid, 0);
      clr_all();
    end

    // R3 retry then R7 drop with R8 serr
    limit = 33'd3; serr_en = 1'b1; dis = 1'b0;
    start_req(1'b0);
    give(3'd1);
    chk("R3 retry rsp", rsp_code, 1);
    chk("R3 still busy", req_ready, 0);
    chk("R2 att_start after retry", att_start, 1);
    give(3'd1);
    chk("R3 second retry rsp", rsp_code, 1);
    give(3'd1);
    chk("R7 drop rsp", rsp_code, 5);
    chk("R7 idle after drop", req_ready, 1);
    chk("R8 serr raised", serr, 1);
    @(negedge clk);
    chk("R8 serr one cycle", serr, 0);

    // R9 counter restart, R8 gated by disable bit
    dis = 1'b1;
    start_req(1'b0);
    give(3'd1);
    chk("R9 fresh count retry", rsp_code, 1);
    give(3'd1);
    chk("R9 fresh count retry2", rsp_code, 1);
    give(3'd1);
    chk("R9 drop at limit", rsp_code, 5);
    chk("R8 serr masked by disable", serr, 0);

    // R8 gated by enable
    dis = 1'b0; serr_en = 1'b0; limit = 33'd1;
    @(negedge clk);
    start_req(1'b0);
    give(3'd1);
    chk("R7 limit one drops first retry", rsp_code, 5);
    chk("R8 serr masked by enable", serr, 0);

    // R7 limit zero acts as one
    limit = 33'd0; serr_en = 1'b1;
    start_req(1'b0);
    give(3'd1);
    chk("R7 limit zero drop", rsp_code, 5);
    chk("R8 serr limit zero", serr, 1);
    @(negedge clk);

    // R1 busy ignores request, then retry then success
    limit = 33'd3;
    start_req(1'b1);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R1 not ready while busy", req_ready, 0);
    chk("R1 no restart", att_start, 0);
    req_valid = 1'b0;
    res_valid = 1'b1; res_term = 3'd1;
    @(negedge clk);
    res_valid = 1'b0;
    chk("R3 retry rsp", rsp_code, 1);
    give(3'd1);
    chk("R1 count kept across ignored req", rsp_code, 1);
    give(3'd2);
    chk("R4 multi disconnect after retries", rsp_code, 2);
    chk("R4 idle", req_ready, 1);

    // R10 sticky / W1C / set wins
    start_req(1'b0);
    give(3'd3);
    start_req(1'b0);
    give(3'd4);
    repeat (3) @(negedge clk);
    chk("R10 sticky", sts, 3'b111);
    sts_clr = 3'b001;
    @(negedge clk);
    sts_clr = '0;
    chk("R10 partial clear", sts, 3'b110);
    start_req(1'b0);
    @(negedge clk);
    res_valid = 1'b1; res_term = 3'd3; sts_clr = 3'b011;
    @(negedge clk);
    res_valid = 1'b0; sts_clr = '0;
    chk("R10 set wins over clear", sts, 3'b111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule